// File: doc/BRIEF.md
# Processor Presence Bitmap

This block records which processor IDs are currently present in the system as a bitmap with one bit per ID. Firmware reads the bitmap through a small read-only byte window: the byte at offset N holds IDs 8N through 8N+7, and bit j of that byte is ID 8N+j. The hardware side reports processor arrival and departure on two event inputs. Each input carries an ID and updates that ID's bit.

Every event, plug or unplug, also produces a one-cycle request. That request sets the processor-change bit (value 0x04) in the general-purpose event status, so the interrupt logic re-evaluates its system control interrupt. While reset is held, the bitmap is loaded from an initial-present vector that describes the processors present at power-on. With the defaults, the block covers 256 IDs through a 32-byte window.

Top module: `cpuhp_presence`

## Requirements
- R1: While rst_n is low, the bitmap loads init_present, where bit i is ID i. After reset, window byte N equals init_present[8N+7:8N]. gpe_sts_set is 0 during and after reset until an event occurs.
- R2: win_rdata shows window byte win_addr in the same cycle: bit j is ID 8*win_addr+j. Offset 0 bit 0 is ID 0 and offset 31 bit 7 is ID 255.
- R3: plug_vld high with plug_id k at a clock edge sets ID k's bit. The new value is readable after that edge.
- R4: unplug_vld high with unplug_id k at a clock edge clears ID k's bit. The new value is readable after that edge.
- R5: If plug and unplug name the same ID in one cycle, the unplug wins and the bit ends cleared. If they name different IDs, both updates apply.
- R6: In the cycle after any cycle with plug_vld or unplug_vld high, gpe_sts_set equals 0x04 (bit 2). Otherwise it is 0. Simultaneous events give one pulse. A plug of a present ID or an unplug of an absent ID still pulses and leaves the bitmap unchanged.
- R7: Window writes (win_wr with any win_wdata) change no bitmap bit and raise no request.
- R8: With no event, the bitmap holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the initial vector |
| init_present | input | 256 | Processors present at power-on, bit i = ID i |
| plug_vld | input | 1 | Processor arrival event |
| plug_id | input | 8 | ID of the arriving processor |
| unplug_vld | input | 1 | Processor departure event |
| unplug_id | input | 8 | ID of the departing processor |
| win_addr | input | 5 | Byte offset into the window |
| win_wr | input | 1 | Window write strobe (ignored) |
| win_wdata | input | 8 | Window write data (ignored) |
| win_rdata | output | 8 | Window byte at win_addr |
| gpe_sts_set | output | 8 | One-cycle event status set mask (0x04 on a change) |

## Verification
After every scenario, all 32 window bytes are compared against a bench bitmap model, so a wrong byte or bit mapping shows up as a stray bit. The bench tests single plugs and unplugs at IDs 0 and 255 to separate the bit order from the byte order. It sends a same-ID plug and unplug together to expose the priority, and a different-ID pair to show that both updates land. It also tries redundant events and window writes: the first must still raise the request, the second must not change anything.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
   localparam int unsigned BITS_PER_BYTE = 8;
   typedef logic [BITS_PER_BYTE-1:0] win_byte_t;
endpackage

// File: rtl/cpuhp_id_dec.sv
module cpuhp_id_dec #(
   parameter int unsigned NUM_IDS = 256,
   parameter int unsigned ID_W    = 8
) (
   input  logic                vld,
   input  logic [ID_W-1:0]     id,
   output logic [NUM_IDS-1:0]  hit
);
   for (genvar i = 0; i < NUM_IDS; i++) begin : g_hit
      assign hit[i] = vld && (id == ID_W'(i));
   end
endmodule

// File: rtl/cpuhp_bitmap.sv
module cpuhp_bitmap #(
   parameter int unsigned NUM_IDS = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IDS-1:0] init_vec,
   input  logic [NUM_IDS-1:0] set_hit,
   input  logic [NUM_IDS-1:0] clr_hit,
   output logic [NUM_IDS-1:0] map_q
);
   for (genvar i = 0; i < NUM_IDS; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          map_q[i] <= init_vec[i];
         else if (clr_hit[i]) map_q[i] <= 1'b0;   // departure wins
         else if (set_hit[i]) map_q[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/cpuhp_window.sv
module cpuhp_window
   import cpuhp_pkg::*;
#(
   parameter int unsigned NUM_IDS  = 256,
   parameter int unsigned ADDR_W   = 5,
   parameter bit          READ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IDS-1:0] map_q,
   input  logic [ADDR_W-1:0]  addr,
   output win_byte_t          rdata
);
   localparam int unsigned NBYTES = NUM_IDS / BITS_PER_BYTE;

   win_byte_t lanes [NBYTES];
   win_byte_t sel;

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign lanes[b] = map_q[b*BITS_PER_BYTE +: BITS_PER_BYTE];
   end

   always_comb begin
      sel = '0;
      if (32'(addr) < NBYTES) sel = lanes[addr];
   end

   if (READ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= sel;
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign rdata = sel;
   end
endmodule

// File: rtl/cpuhp_presence.sv
module cpuhp_presence
   import cpuhp_pkg::*;
#(
   parameter int unsigned NUM_IDS  = 256,
   parameter int unsigned ID_W     = 8,
   parameter int unsigned GPE_W    = 8,
   parameter int unsigned GPE_BIT  = 2,
   parameter bit          READ_REG = 1'b0,
   localparam int unsigned NBYTES  = NUM_IDS / BITS_PER_BYTE,
   localparam int unsigned ADDR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IDS-1:0] init_present,
   input  logic               plug_vld,
   input  logic [ID_W-1:0]    plug_id,
   input  logic               unplug_vld,
   input  logic [ID_W-1:0]    unplug_id,
   input  logic [ADDR_W-1:0]  win_addr,
   input  logic               win_wr,
   input  logic [7:0]         win_wdata,
   output logic [7:0]         win_rdata,
   output logic [GPE_W-1:0]   gpe_sts_set
);
   if (NUM_IDS % BITS_PER_BYTE != 0) begin : g_chk_bytes
      $error("NUM_IDS must be a multiple of 8");
   end
   if (NUM_IDS > (1 << ID_W)) begin : g_chk_idw
      $error("ID_W too narrow for NUM_IDS");
   end
   if (GPE_BIT >= GPE_W) begin : g_chk_gpe
      $error("GPE_BIT outside GPE_W");
   end

   logic [NUM_IDS-1:0] set_hit, clr_hit, map_q;
   logic               evt_q;
   logic               unused_wr;

   // Window is read-only: write strobe and data are accepted and dropped.
   assign unused_wr = win_wr ^ (^win_wdata);

   cpuhp_id_dec #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_plug_dec (
      .vld(plug_vld), .id(plug_id), .hit(set_hit));

   cpuhp_id_dec #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_unplug_dec (
      .vld(unplug_vld), .id(unplug_id), .hit(clr_hit));

   cpuhp_bitmap #(.NUM_IDS(NUM_IDS)) u_map (
      .clk(clk), .rst_n(rst_n), .init_vec(init_present),
      .set_hit(set_hit), .clr_hit(clr_hit), .map_q(map_q));

   cpuhp_window #(.NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W), .READ_REG(READ_REG)) u_win (
      .clk(clk), .rst_n(rst_n), .map_q(map_q), .addr(win_addr), .rdata(win_rdata));

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= plug_vld | unplug_vld;
   end

   assign gpe_sts_set = evt_q ? (GPE_W'(1) << GPE_BIT) : '0;
endmodule

// File: rtl/cpuhp_presence_chk.sv
module cpuhp_presence_chk #(
   parameter int unsigned NUM_IDS = 256,
   parameter int unsigned ID_W    = 8,
   parameter int unsigned GPE_W   = 8,
   parameter int unsigned GPE_BIT = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IDS-1:0] init_present,
   input logic               plug_vld,
   input logic [ID_W-1:0]    plug_id,
   input logic               unplug_vld,
   input logic [ID_W-1:0]    unplug_id,
   input logic [NUM_IDS-1:0] map_q,
   input logic [GPE_W-1:0]   gpe_sts_set
);
   AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (map_q == init_present)); // R1
   AST_PLUG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (plug_vld && !(unplug_vld && unplug_id == plug_id)) |=> map_q[$past(plug_id)]); // R3
   AST_UNPLUG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      unplug_vld |=> !map_q[$past(unplug_id)]); // R5
   AST_GPE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (plug_vld || unplug_vld) |=> (gpe_sts_set == (GPE_W'(1) << GPE_BIT))); // R6
   AST_GPE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(plug_vld || unplug_vld) |=> (gpe_sts_set == '0)); // R7
   AST_GPE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gpe_sts_set)); // R6
   AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(plug_vld || unplug_vld) |=> $stable(map_q)); // R8
endmodule

bind cpuhp_presence cpuhp_presence_chk #(
   .NUM_IDS(NUM_IDS), .ID_W(ID_W), .GPE_W(GPE_W), .GPE_BIT(GPE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .init_present(init_present),
   .plug_vld(plug_vld), .plug_id(plug_id),
   .unplug_vld(unplug_vld), .unplug_id(unplug_id),
   .map_q(map_q), .gpe_sts_set(gpe_sts_set)
);

// File: tb/tb_cpuhp_presence.sv
`timescale 1ns/1ps
module tb_cpuhp_presence;
   logic         clk = 1'b0;
   logic         rst_n;
   logic [255:0] init_present;
   logic         plug_vld, unplug_vld, win_wr;
   logic [7:0]   plug_id, unplug_id, win_wdata;
   logic [4:0]   win_addr;
   logic [7:0]   win_rdata;
   logic [7:0]   gpe_sts_set;

   logic [255:0] model;
   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cpuhp_presence dut (
      .clk(clk), .rst_n(rst_n), .init_present(init_present),
      .plug_vld(plug_vld), .plug_id(plug_id),
      .unplug_vld(unplug_vld), .unplug_id(unplug_id),
      .win_addr(win_addr), .win_wr(win_wr), .win_wdata(win_wdata),
      .win_rdata(win_rdata), .gpe_sts_set(gpe_sts_set));

   task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Compare every window byte against the model (R2 mapping)
   task automatic check_window(string req);
      for (int n = 0; n < 32; n++) begin
         win_addr = 5'(n);
         #1;
         check8(req, win_rdata, model[n*8 +: 8]);
      end
   endtask

   // Drive one cycle of events, then check the pulse and its end
   task automatic send_events(bit p, logic [7:0] pid, bit u, logic [7:0] uid, string req);
      @(negedge clk);
      plug_vld = p; plug_id = pid; unplug_vld = u; unplug_id = uid;
      @(negedge clk);
      plug_vld = 0; unplug_vld = 0;
      if (p && !(u && uid == pid)) model[pid] = 1'b1;
      if (u) model[uid] = 1'b0;
      check8({req, " R6 pulse"}, gpe_sts_set, 8'h04);
      @(negedge clk);
      check8({req, " R6 end"}, gpe_sts_set, 8'h00);
   endtask

   task automatic t_reset;
      check8("R1 gpe at reset", gpe_sts_set, 8'h00);
      check_window("R1 init load");
      win_addr = 0; #1; check8("R2 byte0 IDs0-3", win_rdata, 8'h0F);
      win_addr = 31; #1; check8("R2 byte31 bit7 ID255", win_rdata, 8'h80);
   endtask

   task automatic t_plug;
      send_events(1, 8'd5, 0, 8'd0, "R3 plug 5");
      check_window("R3 plug 5");
      win_addr = 0; #1; check8("R3 byte0 after plug5", win_rdata, 8'h2F);
      send_events(1, 8'd254, 0, 8'd0, "R3 plug 254");
      check_window("R3 plug 254");
   endtask

   task automatic t_unplug;
      send_events(0, 8'd0, 1, 8'd255, "R4 unplug 255");
      win_addr = 31; #1; check8("R4 byte31", win_rdata, 8'h40);
      send_events(0, 8'd0, 1, 8'd0, "R4 unplug 0");
      win_addr = 0; #1; check8("R4 byte0", win_rdata, 8'h2E);
      send_events(1, 8'd255, 0, 8'd0, "R3 replug 255");
      check_window("R4 after unplug/replug");
   endtask

   task automatic t_same_cycle;
      send_events(1, 8'd40, 1, 8'd40, "R5 same id");
      win_addr = 5; #1; check8("R5 unplug wins", win_rdata, 8'h00);
      send_events(1, 8'd41, 1, 8'd100, "R5 different ids");
      check_window("R5 both applied");
      win_addr = 5; #1; check8("R5 ID41 set", win_rdata, 8'h02);
   endtask

   task automatic t_redundant;
      send_events(1, 8'd1, 0, 8'd0, "R6 redundant plug");
      send_events(0, 8'd0, 1, 8'd200, "R6 redundant unplug");
      check_window("R6 redundant no change");
   endtask

   task automatic t_writes;
      for (int n = 0; n < 32; n += 7) begin
         @(negedge clk);
         win_wr = 1; win_addr = 5'(n); win_wdata = ~model[n*8 +: 8];
         @(negedge clk);
         win_wr = 0;
         check8("R7 no gpe on write", gpe_sts_set, 8'h00);
      end
      repeat (3) @(negedge clk);
      check8("R8 quiet gpe", gpe_sts_set, 8'h00);
      check_window("R7 R8 writes ignored, map held");
   endtask

   initial begin
      rst_n = 0; plug_vld = 0; unplug_vld = 0; win_wr = 0;
      plug_id = 0; unplug_id = 0; win_wdata = 0; win_addr = 0;
      init_present = '0;
      init_present[3:0] = 4'hF;
      init_present[100] = 1'b1;
      init_present[200] = 1'b0;
      init_present[255] = 1'b1;
      model = init_present;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_plug();
      t_unplug();
      t_same_cycle();
      t_redundant();
      t_writes();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
      $finish;
   end
endmodule